// File: doc/BRIEF.md
# Dual-Channel Converter Input Demultiplexer

This block is the digital front end of a two-channel converter. It receives two parallel 14-bit data ports and four control strobes, all asynchronous to a fast system clock, and delivers two registered output codes to the converter cores. Each channel has two stages: an input buffer loaded by a write strobe, followed by an output register loaded from that buffer by an update strobe.

A mode pin, sampled only while reset is asserted, picks one of two schemes. In dual mode the channels are independent: each has its own port, write strobe and update strobe. In interleaved mode only port A carries data. Write strobe A then acts as a shared write strobe, and each word it writes is steered to channel A or channel B by a select level. That select comes either from write strobe B, which serves as an external select in this mode, or from an internal toggle that flips on every falling edge of the shared write strobe. Update strobe A becomes a common update for both channels. Update strobe B becomes a steering reset that clears both buffers and points the toggle back at channel A. The toggle can be preset or cleared before a stream starts, so the first word of a stream lands in the intended channel.

The strobes and the data are passed through two flip-flops into the system clock domain, and their edges are detected there. The system clock must run at least four times faster than any strobe. A resolution parameter below 14 keeps the code MSB-justified on the port and forces the unused low bits to zero.

Top module: `dual_dac_frontend`

## Requirements
- R1: With `mode_dual`=1 at reset, a rising edge of `wr_a` loads `port_a` into buffer A and a rising edge of `wr_b` loads `port_b` into buffer B, independently of each other.
- R2: In dual mode, a rising edge of `upd_a` copies buffer A to `out_a` and a rising edge of `upd_b` copies buffer B to `out_b`; the outputs change at no other time. On a coincident write and update, the output takes the buffer value from before the write.
- R3: With `mode_dual`=0 at reset, `port_b` is ignored. A rising edge of `wr_a` stores `port_a` into buffer A when the select is 1 and into buffer B when the select is 0. With `sel_int_en`=0, the select is the level on `wr_b`.
- R4: In interleaved mode, a rising edge of `upd_a` copies both buffers to both outputs in the same cycle. A rising edge of `upd_b` alone changes neither output.
- R5: In interleaved mode with `sel_int_en`=1, the select is an internal toggle that inverts on every falling edge of `wr_a`, and the level on `wr_b` has no effect.
- R6: In interleaved mode, a high `sel_set` forces the toggle to 1 (channel A) and a high `sel_clr` forces it to 0 (channel B). When both are high, `sel_set` wins.
- R7: In interleaved mode, while `upd_b` is high, both buffers are cleared, writes are suppressed and the toggle is forced to 1. The outputs keep their values until the next update.
- R8: With `RES` < `PORT_W`, the low `PORT_W-RES` bits of every stored code, and therefore of both outputs, are 0.
- R9: `mode_dual` is captured only on clock edges with `rst_n` low. A change of `mode_dual` after reset has no effect until the next reset.
- R10: Reset clears both buffers and both outputs and sets the toggle to 1. A strobe transition takes effect on the third rising `clk` edge after it.

Asynchronous inputs must be held stable for at least 4 `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the fastest strobe |
| rst_n | input | 1 | Active-low reset; `mode_dual` is captured while it is low |
| mode_dual | input | 1 | 1 = two independent channels, 0 = interleaved |
| sel_int_en | input | 1 | Interleaved: 1 steers with the internal toggle, 0 with `wr_b` |
| sel_set | input | 1 | Forces the toggle to channel A |
| sel_clr | input | 1 | Forces the toggle to channel B |
| wr_a | input | 1 | Dual: write strobe A. Interleaved: shared write strobe |
| upd_a | input | 1 | Dual: update strobe A. Interleaved: common update |
| upd_b | input | 1 | Dual: update strobe B. Interleaved: steering reset (level) |
| wr_b | input | 1 | Dual: write strobe B. Interleaved: external select level |
| port_a | input | PORT_W | Data port A, MSB-justified |
| port_b | input | PORT_W | Data port B, MSB-justified (dual only) |
| out_a | output | PORT_W | Registered code for channel A |
| out_b | output | PORT_W | Registered code for channel B |

## Verification
The hardest state to reach from the ports is an interleaved stream that starts in a known channel after the toggle has flipped many times. The internal select is invisible at the ports and only shows up in where later words land. The stimulus therefore drives runs of odd and even length between preset, clear, steering-reset and combined preset-and-clear pulses. It keeps toggling `wr_b` throughout, so that the bench would see any leak of the external select. Every write is followed by a common update, which brings the toggle's history out on both outputs. A cycle model in the bench, driven by a three-deep input history queue, is compared with both outputs on every clock.

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend #(
  parameter int PORT_W = 14,
  parameter int RES    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_dual,
  input  logic              sel_int_en,
  input  logic              sel_set,
  input  logic              sel_clr,
  input  logic              wr_a,
  input  logic              upd_a,
  input  logic              upd_b,
  input  logic              wr_b,
  input  logic [PORT_W-1:0] port_a,
  input  logic [PORT_W-1:0] port_b,
  output logic [PORT_W-1:0] out_a,
  output logic [PORT_W-1:0] out_b
);
  localparam int NC = 6;
  localparam int DROP = PORT_W - RES;
  localparam logic [PORT_W-1:0] KEEP = {PORT_W{1'b1}} << DROP;
  localparam int I_WRA = 0, I_UPA = 1, I_UPB = 2, I_WRB = 3, I_SET = 4, I_CLR = 5;

  logic [NC-1:0] c1, c2, c3, rise, fall;
  logic [PORT_W-1:0] a1, a2, b1, b2, buf_a, buf_b;
  logic mode_q, sel_q, iq_rst, sel_eff, upd_b_ev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c1 <= '0; c2 <= '0; c3 <= '0;
      a1 <= '0; a2 <= '0; b1 <= '0; b2 <= '0;
    end else begin
      c1 <= {sel_clr, sel_set, wr_b, upd_b, upd_a, wr_a};
      c2 <= c1; c3 <= c2;
      a1 <= port_a; a2 <= a1;
      b1 <= port_b; b2 <= b1;
    end

  always_ff @(posedge clk)
    if (!rst_n) mode_q <= mode_dual;

  assign rise     = c2 & ~c3;
  assign fall     = ~c2 & c3;
  assign iq_rst   = !mode_q && c2[I_UPB];
  assign sel_eff  = sel_int_en ? sel_q : c2[I_WRB];
  assign upd_b_ev = mode_q ? rise[I_UPB] : rise[I_UPA];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      buf_a <= '0; buf_b <= '0;
    end else if (mode_q) begin
      if (rise[I_WRA]) buf_a <= a2 & KEEP;
      if (rise[I_WRB]) buf_b <= b2 & KEEP;
    end else if (iq_rst) begin
      buf_a <= '0; buf_b <= '0;
    end else if (rise[I_WRA]) begin
      if (sel_eff) buf_a <= a2 & KEEP;
      else         buf_b <= a2 & KEEP;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_a <= '0; out_b <= '0;
    end else begin
      if (rise[I_UPA]) out_a <= buf_a;
      if (upd_b_ev)    out_b <= buf_b;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel_q <= 1'b1;
    else if (!mode_q) begin
      if (iq_rst || c2[I_SET]) sel_q <= 1'b1;
      else if (c2[I_CLR])      sel_q <= 1'b0;
      else if (fall[I_WRA])    sel_q <= ~sel_q;
    end

  AST_DUAL_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> $stable(sel_q)); // R1
  AST_OUTA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise[I_UPA] |=> $stable(out_a)); // R2
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && rise[I_WRA]) |=> ($stable(buf_a) || $stable(buf_b))); // R3
  AST_OUTB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_b_ev |=> $stable(out_b)); // R4
  AST_SEL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && fall[I_WRA] && !iq_rst && !c2[I_SET] && !c2[I_CLR]) |=> (sel_q != $past(sel_q))); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && c2[I_SET]) |=> sel_q); // R6
  AST_IQRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    iq_rst |=> (buf_a == '0 && buf_b == '0 && sel_q)); // R7
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_a & ~KEEP) == '0 && (out_b & ~KEEP) == '0)); // R8
  AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q)); // R9
endmodule

// File: tb/dual_dac_frontend_tb_top.sv
module dual_dac_frontend_tb_top;
  localparam int PW = 14;
  localparam int RS = 12;
  localparam logic [PW-1:0] KM = {PW{1'b1}} << (PW - RS);

  logic clk = 0, rst_n = 0, mode_dual = 1, sel_int_en = 0;
  logic [5:0] ctl = '0;
  logic [PW-1:0] port_a = '0, port_b = '0, out_a, out_b;
  int vecs = 0, errs = 0;
  bit done = 0, started = 0;
  string tag = "R10";

  always #2 clk = ~clk;

  dual_dac_frontend #(.PORT_W(PW), .RES(RS)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_dual(mode_dual), .sel_int_en(sel_int_en),
    .sel_set(ctl[4]), .sel_clr(ctl[5]), .wr_a(ctl[0]), .upd_a(ctl[1]),
    .upd_b(ctl[2]), .wr_b(ctl[3]), .port_a(port_a), .port_b(port_b),
    .out_a(out_a), .out_b(out_b));

  // reference model: three-deep input history, action on the older pair
  logic [6+2*PW-1:0] hist[$];
  logic m_dual = 1, m_sel = 1;
  logic [PW-1:0] m_ba = '0, m_bb = '0, m_oa = '0, m_ob = '0;

  always @(posedge clk) begin
    logic [5:0] cn, cp, r, f;
    logic [PW-1:0] da, db;
    logic s;
    if (!rst_n) begin
      m_dual = mode_dual; m_sel = 1;
      m_ba = '0; m_bb = '0; m_oa = '0; m_ob = '0;
      hist.delete();
      repeat (3) hist.push_front('0);
    end else begin
      {cn, db, da} = hist[1];
      cp = hist[2][6+2*PW-1:2*PW];
      r = cn & ~cp; f = ~cn & cp;
      if (m_dual) begin
        if (r[1]) m_oa = m_ba;
        if (r[2]) m_ob = m_bb;
        if (r[0]) m_ba = da & KM;
        if (r[3]) m_bb = db & KM;
      end else begin
        s = sel_int_en ? m_sel : cn[3];
        if (r[1]) begin m_oa = m_ba; m_ob = m_bb; end
        if (cn[2]) begin m_ba = '0; m_bb = '0; end
        else if (r[0]) begin
          if (s) m_ba = da & KM; else m_bb = da & KM;
        end
        if (cn[2] || cn[4]) m_sel = 1;
        else if (cn[5]) m_sel = 0;
        else if (f[0]) m_sel = ~m_sel;
      end
      hist.push_front({ctl, port_b, port_a});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) if (started && !done) begin
    vecs++;
    if (out_a !== m_oa) begin errs++; $display("FAIL %s out_a=%h expected=%h", tag, out_a, m_oa); end
    if (out_b !== m_ob) begin errs++; $display("FAIL %s out_b=%h expected=%h", tag, out_b, m_ob); end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse(int i);
    @(negedge clk); ctl[i] = 1; tick(4); ctl[i] = 0; tick(4);
  endtask
  task automatic new_data();
    port_a = PW'($urandom); port_b = PW'($urandom);
  endtask
  task automatic do_reset(logic md);
    @(negedge clk); mode_dual = md; rst_n = 0; ctl = '0; tick(4); rst_n = 1; tick(2);
  endtask

  initial begin
    do_reset(1); started = 1;
    tag = "R10"; tick(3);
    tag = "R1 R2";
    for (int k = 0; k < 4; k++) begin
      new_data(); pulse(0); new_data(); pulse(3); pulse(1); pulse(2);
    end
    tag = "R2 coincident";
    new_data(); @(negedge clk); ctl[0] = 1; ctl[1] = 1; tick(4); ctl = '0; tick(4); pulse(1);
    tag = "R9";
    @(negedge clk); mode_dual = 0;
    new_data(); ctl[3] = 1; pulse(0); ctl[3] = 0; tick(4); pulse(1); pulse(2);
    tag = "R3 R4";
    do_reset(0);
    for (int k = 0; k < 6; k++) begin
      new_data(); ctl[3] = k[0]; pulse(0);
      if (k % 2 == 1) pulse(1);
    end
    ctl[3] = 0; tick(4);
    tag = "R4 upd_b only";
    new_data(); ctl[3] = 1; tick(4); pulse(0); ctl[3] = 0; tick(4); pulse(2); pulse(1);
    tag = "R7";
    new_data(); ctl[3] = 1; tick(4); pulse(0); pulse(1);
    @(negedge clk); ctl[2] = 1; tick(2); new_data(); ctl[0] = 1; tick(4); ctl[0] = 0; tick(3); ctl[2] = 0; tick(4);
    pulse(1); ctl[3] = 0;
    tag = "R5";
    sel_int_en = 1; pulse(4);
    for (int k = 0; k < 7; k++) begin
      new_data(); ctl[3] = k[1]; pulse(0); pulse(1);
    end
    tag = "R6";
    pulse(5);
    for (int k = 0; k < 3; k++) begin new_data(); pulse(0); pulse(1); end
    @(negedge clk); ctl[4] = 1; ctl[5] = 1; tick(4); ctl[4] = 0; ctl[5] = 0; tick(4);
    new_data(); pulse(0); pulse(1);
    tag = "R7 sel";
    pulse(5); new_data(); pulse(0); pulse(2); new_data(); pulse(0); pulse(1);
    tag = "R8";
    port_a = '1; pulse(0); port_a = '1; pulse(0); pulse(1);
    do_reset(1); port_a = '1; port_b = '1; pulse(0); pulse(3); pulse(1); pulse(2);
    tag = "R10 reset";
    do_reset(1); tick(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1; errs++;
      $display("FAIL watchdog expired in phase %s", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule